// File: doc/BRIEF.md
# Backplane Cycle Controller

This block sits between a processor's simple synchronous register bus and a shared backplane of plug-in modules. Software picks a module and one of its subaddresses, says whether the access is a read or a write and whether it is analog, then writes that word to the address register. Writing the address register launches exactly one backplane cycle. The controller raises a request strobe toward the selected module and waits for an acknowledge, a negative acknowledge or a timeout. It then captures any read data and records completion and error flags.

Four 16-bit registers are decoded from bits 2:1 of the byte offset. A digital cycle gives up after a short window. An analog cycle waits much longer, because the module converts a sample before it answers. An interrupt line can be enabled separately for analog and digital cycles. Once raised, it stays up until software reads the status register. A control bit can force the cycle engine back to idle and hold it there.

Top module: `bus_cycle_ctrl`

## Requirements
- R1: After reset all four registers read 0x0000, and bp_req and irq are low.
- R2: Register map by byte offset: 0 address, 2 data, 4 status, 6 control. Address word fields are: bit 15 analog, bit 14 read, bits 11:8 module number, bits 3:0 subaddress. These fields drive bp_analog, bp_read, bp_mod and bp_sub, and the whole word reads back.
- R3: A write to the address register while idle and not held in reset loads the address, clears the ready flag and raises bp_req on the next cycle.
- R4: On bp_ack the cycle ends: bp_req falls and ready (status bit 0) sets. A digital read stores bp_rdata[7:0] zero-extended in data bits 11:0, and an analog read stores bp_rdata[11:0]. During a write cycle bp_wdata carries data register bits 7:0.
- R5: On bp_nack, or after DIG_TMO (64) request cycles of a digital cycle with no answer, the cycle ends with ready, no-acknowledge (status bit 2) and the error summary (data bit 15) set.
- R6: An analog cycle with no answer ends after ANA_TMO (4096) request cycles with ready, ADC timeout (status bit 3) and the error summary set.
- R7: An address write while a cycle runs sets overlap (status bit 1) and the error summary. The write is otherwise ignored: the running cycle keeps its target and still completes.
- R8: While a cycle runs, data register writes are ignored and bp_mod, bp_sub and bp_wdata stay stable.
- R9: Any write to the status register clears overlap, no-acknowledge, ADC timeout and the error summary, and leaves ready unchanged.
- R10: At completion irq sets if the enable for that cycle type is on: control bit 0 for analog, bit 1 for digital. irq then stays high until the status register is read.
- R11: While control bit 2 is set, any running cycle is abandoned within one clock, bp_req stays low, and address writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_sel | input | 1 | Register access this cycle |
| cpu_wr | input | 1 | 1 write, 0 read |
| cpu_off | input | 3 | Byte offset of the register |
| cpu_wdata | input | 16 | Write data |
| cpu_rdata | output | 16 | Read data (combinational) |
| irq | output | 1 | Completion interrupt |
| bp_req | output | 1 | Backplane cycle strobe |
| bp_analog | output | 1 | Cycle is analog |
| bp_read | output | 1 | Cycle is a read |
| bp_mod | output | 4 | Selected module |
| bp_sub | output | 4 | Selected subaddress |
| bp_wdata | output | 8 | Write data to module |
| bp_ack | input | 1 | Module acknowledge |
| bp_nack | input | 1 | Module refusal |
| bp_rdata | input | 12 | Read data from module |

## Verification
The bench counts the exact length of the request strobe in both the digital and the analog timeout cases. An off-by-one timer shows up as 63 or 65 cycles, and a timer that picks the wrong limit shows up as a flag in the wrong status bit. It issues an address write and a data write in the middle of a running cycle. A design without the lock would retarget the module or corrupt bp_wdata, and one without overlap detection would leave status bit 1 clear. It checks that irq survives a data register read and falls only after a status read. It also asserts the state-machine reset during a live cycle, where a faulty design keeps strobing or accepts a new start.

// File: rtl/bus_cycle_ctrl.sv
module bus_cycle_ctrl #(
  parameter int DIG_TMO = 64,
  parameter int ANA_TMO = 4096
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cpu_sel,
  input  logic        cpu_wr,
  input  logic [2:0]  cpu_off,
  input  logic [15:0] cpu_wdata,
  output logic [15:0] cpu_rdata,
  output logic        irq,
  output logic        bp_req,
  output logic        bp_analog,
  output logic        bp_read,
  output logic [3:0]  bp_mod,
  output logic [3:0]  bp_sub,
  output logic [7:0]  bp_wdata,
  input  logic        bp_ack,
  input  logic        bp_nack,
  input  logic [11:0] bp_rdata
);
  localparam int TW = $clog2(ANA_TMO + 1);
  localparam logic [1:0] REG_ADDR = 2'd0;
  localparam logic [1:0] REG_DATA = 2'd1;
  localparam logic [1:0] REG_STAT = 2'd2;
  localparam logic [1:0] REG_CTRL = 2'd3;

  logic [15:0]   addr_q;
  logic [11:0]   data_q;
  logic [2:0]    ctrl_q;
  logic [TW-1:0] tmr_q;
  logic          busy_q, rdy_q, ovl_q, nack_q, ato_q, err_q, irq_q;

  wire wr_addr = cpu_sel & cpu_wr & (cpu_off[2:1] == REG_ADDR);
  wire wr_data = cpu_sel & cpu_wr & (cpu_off[2:1] == REG_DATA);
  wire wr_stat = cpu_sel & cpu_wr & (cpu_off[2:1] == REG_STAT);
  wire wr_ctrl = cpu_sel & cpu_wr & (cpu_off[2:1] == REG_CTRL);
  wire rd_stat = cpu_sel & ~cpu_wr & (cpu_off[2:1] == REG_STAT);

  wire smr     = ctrl_q[2];
  wire is_ana  = addr_q[15];
  wire start   = wr_addr & ~busy_q & ~smr;
  wire overlap = wr_addr & busy_q & ~smr;
  wire live    = busy_q & ~smr;

  wire [TW-1:0] limit = is_ana ? TW'(ANA_TMO - 1) : TW'(DIG_TMO - 1);
  wire expired  = (tmr_q == limit);
  wire done_ok  = live & bp_ack & ~bp_nack;
  wire done_nak = live & bp_nack;
  wire done_tmo = live & ~bp_ack & ~bp_nack & expired;
  wire done     = done_ok | done_nak | done_tmo;
  wire set_nack = done_nak | (done_tmo & ~is_ana);
  wire set_ato  = done_tmo & is_ana;
  wire irq_en   = is_ana ? ctrl_q[0] : ctrl_q[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      busy_q <= 1'b0;
      rdy_q  <= 1'b0;
      tmr_q  <= '0;
    end else if (start) begin
      addr_q <= cpu_wdata;
      busy_q <= 1'b1;
      rdy_q  <= 1'b0;
      tmr_q  <= '0;
    end else if (smr) begin
      busy_q <= 1'b0;
    end else if (done) begin
      busy_q <= 1'b0;
      rdy_q  <= 1'b1;
    end else if (busy_q) begin
      tmr_q  <= tmr_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      data_q <= '0;
    else if (wr_data && !busy_q)
      data_q <= cpu_wdata[11:0];
    else if (done_ok && addr_q[14])
      data_q <= is_ana ? bp_rdata : {4'h0, bp_rdata[7:0]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovl_q  <= 1'b0;
      nack_q <= 1'b0;
      ato_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      ovl_q  <= overlap  | (ovl_q  & ~wr_stat);
      nack_q <= set_nack | (nack_q & ~wr_stat);
      ato_q  <= set_ato  | (ato_q  & ~wr_stat);
      err_q  <= overlap | set_nack | set_ato | (err_q & ~wr_stat);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= cpu_wdata[2:0];
      if (done && irq_en) irq_q <= 1'b1;
      else if (rd_stat)   irq_q <= 1'b0;
    end
  end

  always_comb begin
    case (cpu_off[2:1])
      REG_ADDR: cpu_rdata = addr_q;
      REG_DATA: cpu_rdata = {err_q, 3'b000, data_q};
      REG_STAT: cpu_rdata = {12'h000, ato_q, nack_q, ovl_q, rdy_q};
      default:  cpu_rdata = {13'h0000, ctrl_q};
    endcase
  end

  assign irq       = irq_q;
  assign bp_req    = live;
  assign bp_analog = addr_q[15];
  assign bp_read   = addr_q[14];
  assign bp_mod    = addr_q[11:8];
  assign bp_sub    = addr_q[3:0];
  assign bp_wdata  = data_q[7:0];
endmodule

// File: rtl/bus_cycle_chk.sv
module bus_cycle_chk #(
  parameter int ANA_TMO = 4096
) (
  input logic       clk,
  input logic       rst_n,
  input logic       bp_req,
  input logic       bp_ack,
  input logic [3:0] bp_mod,
  input logic [3:0] bp_sub,
  input logic [7:0] bp_wdata,
  input logic       irq,
  input logic       rd_stat,
  input logic       wr_addr,
  input logic       rdy_q,
  input logic       ovl_q,
  input logic       smr,
  input logic       busy_q
);
  int run_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) run_cnt <= 0;
    else        run_cnt <= bp_req ? run_cnt + 1 : 0;
  end

  always @(posedge clk) begin
    if (rst_n) begin
      AST_TMO_WINDOW: assert (run_cnt <= ANA_TMO) else $error("strobe longer than limit"); // R6
    end
  end

  AST_START_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q && wr_addr && !smr |=> bp_req); // R3
  AST_ACK_COMPLETES: assert property (@(posedge clk) disable iff (!rst_n)
    bp_req && bp_ack |=> !bp_req && rdy_q); // R4
  AST_OVERLAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    bp_req && wr_addr |=> ovl_q); // R7
  AST_TARGET_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    bp_req && $past(bp_req) |-> $stable(bp_mod) && $stable(bp_sub) && $stable(bp_wdata)); // R8
  AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !rd_stat |=> irq); // R10
  AST_SMR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    smr |=> !busy_q); // R11
endmodule

bind bus_cycle_ctrl bus_cycle_chk #(.ANA_TMO(ANA_TMO)) u_chk (
  .clk(clk), .rst_n(rst_n), .bp_req(bp_req), .bp_ack(bp_ack),
  .bp_mod(bp_mod), .bp_sub(bp_sub), .bp_wdata(bp_wdata), .irq(irq),
  .rd_stat(rd_stat), .wr_addr(wr_addr), .rdy_q(rdy_q), .ovl_q(ovl_q),
  .smr(smr), .busy_q(busy_q)
);

// File: tb/sim_bus_cycle_ctrl.sv
module sim_bus_cycle_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cpu_sel = 1'b0, cpu_wr = 1'b0;
  logic [2:0]  cpu_off = '0;
  logic [15:0] cpu_wdata = '0, cpu_rdata;
  logic        irq, bp_req, bp_analog, bp_read;
  logic [3:0]  bp_mod, bp_sub;
  logic [7:0]  bp_wdata;
  logic        bp_ack = 1'b0, bp_nack = 1'b0;
  logic [11:0] bp_rdata = '0;
  int n_chk = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_cycle_ctrl u0 (.*);

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] off, input logic [15:0] d);
    @(negedge clk); cpu_sel = 1; cpu_wr = 1; cpu_off = off; cpu_wdata = d;
    @(negedge clk); cpu_sel = 0; cpu_wr = 0;
  endtask

  task automatic rd(input logic [2:0] off, output logic [15:0] d);
    @(negedge clk); cpu_sel = 1; cpu_wr = 0; cpu_off = off;
    #1 d = cpu_rdata;
    @(negedge clk); cpu_sel = 0;
  endtask

  task automatic ack(input logic [11:0] d);
    @(negedge clk); bp_ack = 1; bp_rdata = d;
    @(negedge clk); bp_ack = 0;
  endtask

  task automatic count_req(output int n);
    n = 0;
    while (bp_req && n < 10000) begin n++; @(negedge clk); end
  endtask

  task automatic t_reset;
    logic [15:0] v;
    for (int i = 0; i < 4; i++) begin rd(3'(2*i), v); chk("R1 reg", v, 16'h0000); end
    chk("R1 bp_req", {15'b0, bp_req}, 16'h0);
    chk("R1 irq", {15'b0, irq}, 16'h0);
  endtask

  task automatic t_dig_read;
    logic [15:0] v;
    wr(6, 16'h0002);
    wr(0, 16'h4503);
    chk("R3 bp_req", {15'b0, bp_req}, 16'h1);
    chk("R2 fields", {bp_analog, bp_read, 6'b0, bp_mod, bp_sub}, 16'h4053);
    rd(0, v); chk("R2 addr readback", v, 16'h4503);
    rd(4, v); chk("R3 ready cleared", v, 16'h0000);
    ack(12'hABC);
    chk("R4 bp_req fell", {15'b0, bp_req}, 16'h0);
    chk("R10 irq digital", {15'b0, irq}, 16'h1);
    rd(2, v); chk("R4 digital 8-bit data", v, 16'h00BC);
    chk("R10 irq kept on data read", {15'b0, irq}, 16'h1);
    rd(4, v); chk("R4 ready", v, 16'h0001);
    chk("R10 irq cleared by status read", {15'b0, irq}, 16'h0);
  endtask

  task automatic t_ana_read;
    logic [15:0] v;
    wr(6, 16'h0000);
    wr(0, 16'hC20A);
    chk("R2 analog flag", {14'b0, bp_analog, bp_read}, 16'h3);
    ack(12'h5A7);
    rd(2, v); chk("R4 analog 12-bit data", v, 16'h05A7);
    chk("R10 irq disabled", {15'b0, irq}, 16'h0);
  endtask

  task automatic t_write_lock;
    logic [15:0] v;
    wr(2, 16'h003C);
    wr(0, 16'h0107);
    chk("R4 write data out", {8'b0, bp_wdata}, 16'h003C);
    wr(2, 16'h00FF);
    chk("R8 data locked", {8'b0, bp_wdata}, 16'h003C);
    wr(0, 16'h4F0F);
    chk("R7 target kept", {8'b0, bp_mod, bp_sub}, 16'h0017);
    chk("R7 cycle continues", {15'b0, bp_req}, 16'h1);
    ack(12'h000);
    rd(4, v); chk("R7 overlap flag", v, 16'h0003);
    rd(2, v); chk("R7 error summary", v, 16'h803C);
    rd(0, v); chk("R8 addr unchanged", v, 16'h0107);
    wr(4, 16'hFFFF);
    rd(4, v); chk("R9 flags cleared, ready kept", v, 16'h0001);
    rd(2, v); chk("R9 error summary cleared", v, 16'h003C);
  endtask

  task automatic t_nack;
    logic [15:0] v;
    wr(0, 16'h4200);
    @(negedge clk); bp_nack = 1;
    @(negedge clk); bp_nack = 0;
    chk("R5 nack ends cycle", {15'b0, bp_req}, 16'h0);
    rd(4, v); chk("R5 nack status", v, 16'h0005);
    rd(2, v); chk("R5 nack error", {v[15], 15'b0}, 16'h8000);
    wr(4, 16'h0000);
  endtask

  task automatic t_dig_tmo;
    logic [15:0] v;
    int n;
    wr(0, 16'h4300);
    count_req(n);
    chk("R5 digital timeout length", 16'(n), 16'd64);
    rd(4, v); chk("R5 timeout status", v, 16'h0005);
    wr(4, 16'h0000);
  endtask

  task automatic t_ana_tmo;
    logic [15:0] v;
    int n;
    wr(6, 16'h0001);
    wr(0, 16'hC300);
    count_req(n);
    chk("R6 analog timeout length", 16'(n), 16'd4096);
    chk("R10 irq analog", {15'b0, irq}, 16'h1);
    rd(4, v); chk("R6 ato status", v, 16'h0009);
    rd(2, v); chk("R6 error summary", {v[15], 15'b0}, 16'h8000);
    chk("R10 irq cleared", {15'b0, irq}, 16'h0);
    wr(4, 16'h0000);
  endtask

  task automatic t_smr;
    logic [15:0] v;
    wr(6, 16'h0000);
    wr(0, 16'h4400);
    chk("R11 cycle running", {15'b0, bp_req}, 16'h1);
    wr(6, 16'h0004);
    @(negedge clk);
    chk("R11 cycle abandoned", {15'b0, bp_req}, 16'h0);
    wr(0, 16'h4500);
    chk("R11 no start while held", {15'b0, bp_req}, 16'h0);
    rd(0, v); chk("R11 addr write ignored", v, 16'h4400);
    rd(4, v); chk("R11 no completion", v, 16'h0000);
    wr(6, 16'h0000);
    chk("R11 idle after release", {15'b0, bp_req}, 16'h0);
    wr(0, 16'h4600);
    chk("R11 start after release", {15'b0, bp_req}, 16'h1);
    ack(12'h011);
    rd(2, v); chk("R11 cycle completes", v, 16'h0011);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_dig_read();
    t_ana_read();
    t_write_lock();
    t_nack();
    t_dig_tmo();
    t_ana_tmo();
    t_smr();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule